// File: doc/BRIEF.md
# Wide Unsigned/Signed Sequential Divider

This block divides a 128-bit dividend by a 64-bit divisor. It returns a 128-bit quotient and a 64-bit remainder. The core is a restoring shift-and-subtract engine that settles one quotient bit per clock. A caller pulses `start` with the operands on the inputs. `busy` stays high while the engine iterates. `done` then rises and holds the results until the next accepted start.

The partial remainder is held one bit wider than the divisor. With a divisor of `2^63` or more, a shift can push a 1 above bit 63 after a step that records quotient bit 0. That carried bit takes part in the next compare and subtract. A parameter can drop the extra bit for callers who guarantee that the divisor's top bit is clear.

A thin sign stage sits around the unsigned core. In signed mode, both operands are turned into magnitudes before the run, and the results are negated afterwards as needed. The one signed quotient that does not fit (most negative value divided by -1) is flagged and not computed. A zero divisor is reported at once, without iterating.

Top module: `wide_divider`

## Requirements
- R1: In unsigned mode (`signedMode`=0) with a non-zero divisor, `quotient` and `remainder` satisfy dividend = quotient*divisor + remainder, with remainder < divisor.
- R2: A start accepted with a non-zero divisor and no signed overflow raises `busy` on the accepting edge. `done` rises, and `busy` falls, on the 128th rising edge after that edge. `busy` and `done` are never high together.
- R3: Divisors with bit 63 set give correct results, including the case where a 1 is shifted above the divisor width. One example is the dividend 0x0202_0000 followed by 96 zero bits, divided by 0x9000_0000_0000_0000.
- R4: A zero divisor, in either mode, sets `divByZero` and `done` on the accepting edge itself, without raising `busy`. It gives a quotient of all ones and a remainder equal to the dividend's low 64 bits.
- R5: In signed mode (`signedMode`=1), the operands are two's complement. The quotient truncates toward zero, and a non-zero remainder carries the dividend's sign.
- R6: In signed mode, the dividend 0x8000...0 (bit 127 only) divided by all-ones (-1) sets `overflow` and `done` on the accepting edge. The quotient equals the dividend and the remainder is zero.
- R7: While `done` is high and no new start is accepted, `quotient`, `remainder`, `divByZero` and `overflow` hold their values. An accepted start clears `done` and both flags.
- R8: A `start` pulse while `busy` is high is ignored. The running division keeps its completion edge and its result.
- R9: After reset, `busy`, `done`, `divByZero` and `overflow` are 0, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted only when not busy |
| signedMode | input | 1 | 1: operands are two's complement; 0: unsigned |
| dividend | input | 128 | Dividend, sampled on the accepting edge |
| divisor | input | 64 | Divisor, sampled on the accepting edge |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | Results valid; held until next accepted start |
| quotient | output | 128 | Quotient |
| remainder | output | 64 | Remainder |
| divByZero | output | 1 | Last accepted request had a zero divisor |
| overflow | output | 1 | Last accepted signed request was most-negative / -1 |

## Verification
Two events can land in the same cycle: a fresh `start` and a division still in progress. The bench raises `start` with different operands in the middle of a run. It then judges the outcome by the unchanged completion cycle and by a result that matches the original operands. A second overlap is a new start arriving in the cycle after `done` while results are held. The bench checks that `done` drops at the next edge and that the held values do not leak into the new run. Random operands with full-width, top-bit-set and narrow divisors, in both modes, are compared against quotients computed by bench functions.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef struct packed {
    logic loadRun;   // capture magnitudes and begin iterating
    logic loadZero;  // zero divisor: write fixed result now
    logic loadOvf;   // signed overflow: write fixed result now
    logic run;       // perform one shift/subtract step
    logic finish;    // last step: write signed-corrected outputs
  } wdivStrobes_t;
endpackage

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
  import wdiv_pkg::*;
#(
  parameter int STEPS = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         opZero,
  input  logic         opOvf,
  output wdivStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         divByZero,
  output logic         overflow
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt;
  logic accept;

  assign accept = start && !busy;

  always_comb begin
    strb.loadZero = accept && opZero;
    strb.loadOvf  = accept && !opZero && opOvf;
    strb.loadRun  = accept && !opZero && !opOvf;
    strb.run      = busy;
    strb.finish   = busy && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      divByZero <= 1'b0;
      overflow  <= 1'b0;
      cnt       <= '0;
    end else if (accept) begin
      busy      <= strb.loadRun;
      done      <= !strb.loadRun;
      divByZero <= opZero;
      overflow  <= strb.loadOvf;
      cnt       <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
      if (strb.finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_run_continues_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.finish |=> busy && !done);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> (cnt == $past(cnt) + CW'(1)) || done);

  assert_zero_fast_R4: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && opZero |=> done && divByZero && !busy);
endmodule

// File: rtl/wdiv_dpath.sv
module wdiv_dpath
  import wdiv_pkg::*;
#(
  parameter int NW         = 128,
  parameter int DW         = 64,
  parameter bit KEEP_CARRY = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdivStrobes_t  strb,
  input  logic          signedMode,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          opZero,
  output logic          opOvf,
  output logic [NW-1:0] quotient,
  output logic [DW-1:0] remainder
);
  localparam logic [NW-1:0] MOST_NEG = {1'b1, {(NW-1){1'b0}}};

  logic [DW-1:0] remReg, divReg;
  logic [NW-1:0] qReg;
  logic          negQ, negR;

  logic          dvdNeg, dvsNeg;
  logic [NW-1:0] dvdAbs;
  logic [DW-1:0] dvsAbs;
  logic [DW:0]   trial, diff;
  logic          fits;
  logic [DW-1:0] nextRem;
  logic [NW-1:0] nextQ;

  assign dvdNeg = signedMode && dividend[NW-1];
  assign dvsNeg = signedMode && divisor[DW-1];
  assign dvdAbs = dvdNeg ? -dividend : dividend;
  assign dvsAbs = dvsNeg ? -divisor : divisor;
  assign opZero = (divisor == '0);
  assign opOvf  = signedMode && (dividend == MOST_NEG) && (&divisor);

  generate
    if (KEEP_CARRY) begin : g_carry
      assign trial = {remReg, qReg[NW-1]};
    end else begin : g_nocarry
      assign trial = {1'b0, remReg[DW-2:0], qReg[NW-1]};
    end
  endgenerate

  assign fits    = (trial >= {1'b0, divReg});
  assign diff    = trial - {1'b0, divReg};
  assign nextRem = fits ? diff[DW-1:0] : trial[DW-1:0];
  assign nextQ   = {qReg[NW-2:0], fits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg    <= '0;
      divReg    <= '0;
      qReg      <= '0;
      negQ      <= 1'b0;
      negR      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (strb.loadRun) begin
        remReg <= '0;
        qReg   <= dvdAbs;
        divReg <= dvsAbs;
        negQ   <= dvdNeg ^ dvsNeg;
        negR   <= dvdNeg;
      end
      if (strb.loadZero) begin
        quotient  <= '1;
        remainder <= dividend[DW-1:0];
      end
      if (strb.loadOvf) begin
        quotient  <= dividend;
        remainder <= '0;
      end
      if (strb.run) begin
        remReg <= nextRem;
        qReg   <= nextQ;
        if (strb.finish) begin
          quotient  <= negQ ? -nextQ : nextQ;
          remainder <= negR ? -nextRem : nextRem;
        end
      end
    end
  end

  assert_partial_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.run || strb.loadRun |=> remReg < divReg);
endmodule

// File: rtl/wide_divider.sv
module wide_divider
  import wdiv_pkg::*;
#(
  parameter int NW         = 128,
  parameter int DW         = 64,
  parameter bit KEEP_CARRY = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          signedMode,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          divByZero,
  output logic          overflow
);
  wdivStrobes_t strb;
  logic opZero, opOvf;

  wdiv_ctrl #(.STEPS(NW)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opZero(opZero), .opOvf(opOvf),
    .strb(strb), .busy(busy), .done(done), .divByZero(divByZero), .overflow(overflow)
  );

  wdiv_dpath #(.NW(NW), .DW(DW), .KEEP_CARRY(KEEP_CARRY)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .opZero(opZero), .opOvf(opOvf),
    .quotient(quotient), .remainder(remainder)
  );

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(quotient) && $stable(remainder)
                       && $stable(divByZero) && $stable(overflow));

  assert_zero_result_R4: assert property (@(posedge clk) disable iff (!rstN)
    done && divByZero |-> &quotient);

  assert_ovf_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && overflow |-> remainder == '0 && quotient[NW-1]);
endmodule

// File: tb/wide_divider_tb_top.sv
module wide_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [127:0] dividend = '0;
  logic [63:0]  divisor = '0;
  logic         busy, done, divByZero, overflow;
  logic [127:0] quotient;
  logic [63:0]  remainder;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_divider dut_i (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference results from the requirements (R1, R4, R5, R6)
  task automatic model(input logic [127:0] a, input logic [63:0] b, input logic s,
                       output logic [127:0] q, output logic [63:0] r,
                       output logic z, output logic o);
    logic [127:0] am, bm, qm, rm;
    logic na, nb;
    z = 1'b0; o = 1'b0;
    if (b == 64'd0) begin
      z = 1'b1; q = '1; r = a[63:0];
    end else if (s && a == {1'b1, 127'd0} && b == '1) begin
      o = 1'b1; q = a; r = '0;
    end else begin
      na = s && a[127];
      nb = s && b[63];
      am = na ? (~a + 128'd1) : a;
      bm = nb ? {64'd0, ~b + 64'd1} : {64'd0, b};
      qm = am / bm;
      rm = am % bm;
      q = (na ^ nb) ? (~qm + 128'd1) : qm;
      rm = na ? (~rm + 128'd1) : rm;
      r = rm[63:0];
    end
  endtask

  task automatic runOp(input logic [127:0] a, input logic [63:0] b, input logic s,
                       input bit poke, input string req);
    logic [127:0] eq; logic [63:0] er; logic ez, eo;
    int cyc;
    int expCyc;
    logic [127:0] hq; logic [63:0] hr;
    model(a, b, s, eq, er, ez, eo);
    expCyc = (ez || eo) ? 1 : 129;
    @(negedge clk);
    dividend = a; divisor = b; signedMode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (expCyc > 1) begin
      check(busy && !done, "R2", "busy after accept / R7 done cleared",
            {126'd0, busy, done}, 128'd2);
    end
    while (!done && cyc < 300) begin
      if (poke && cyc == 5) begin
        start = 1'b1; dividend = ~a; divisor = b ^ 64'h5A5A;
        signedMode = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == expCyc, poke ? "R8" : "R2", "done latency", 128'(cyc), 128'(expCyc));
    check(!busy, "R2", "busy low at done", {127'd0, busy}, 128'd0);
    check(quotient == eq, req, "quotient", quotient, eq);
    check(remainder == er, req, "remainder", {64'd0, remainder}, {64'd0, er});
    check(divByZero == ez && overflow == eo, req, "flags",
          {126'd0, divByZero, overflow}, {126'd0, ez, eo});
    hq = quotient; hr = remainder;
    repeat (3) @(negedge clk);
    check(done && quotient == hq && remainder == hr && divByZero == ez && overflow == eo,
          "R7", "held results", quotient, hq);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rndDiv(input int shape);
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    case (shape)
      0: v = v;
      1: v[63] = 1'b1;
      default: v = v >> $urandom_range(1, 63);
    endcase
    if (v == 64'd0) v = 64'd3;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !divByZero && !overflow, "R9", "reset flags",
          {124'd0, busy, done, divByZero, overflow}, 128'd0);
    check(quotient == '0 && remainder == '0, "R9", "reset results", quotient, 128'd0);
    rstN = 1'b1;

    // R3: carry above divisor width
    runOp({32'h0202_0000, 96'd0}, 64'h9000_0000_0000_0000, 1'b0, 1'b0, "R3");
    runOp('1, '1, 1'b0, 1'b0, "R3");
    runOp({64'hFFFF_FFFF_FFFF_FFFE, 64'h1}, 64'h8000_0000_0000_0001, 1'b0, 1'b0, "R3");
    // R1: edges
    runOp(128'd0, 64'd7, 1'b0, 1'b0, "R1");
    runOp(128'd5, 64'd9, 1'b0, 1'b0, "R1");
    runOp('1, 64'd1, 1'b0, 1'b0, "R1");
    // R4: zero divisor both modes
    runOp(rnd128(), 64'd0, 1'b0, 1'b0, "R4");
    runOp({1'b1, 127'd0}, 64'd0, 1'b1, 1'b0, "R4");
    // R6: signed overflow; and neighbours that are not overflow (R5)
    runOp({1'b1, 127'd0}, '1, 1'b1, 1'b0, "R6");
    runOp({1'b1, 127'd0}, 64'd1, 1'b1, 1'b0, "R5");
    runOp({1'b1, 127'd0}, '1, 1'b0, 1'b0, "R1");
    runOp(-128'sd7, 64'd2, 1'b1, 1'b0, "R5");
    runOp(128'd7, -64'sd2, 1'b1, 1'b0, "R5");
    runOp(-128'sd7, -64'sd2, 1'b1, 1'b0, "R5");
    // R8: start while busy
    runOp(rnd128(), rndDiv(1), 1'b0, 1'b1, "R8");
    runOp(rnd128(), rndDiv(2), 1'b1, 1'b1, "R8");

    for (int i = 0; i < 36; i++) runOp(rnd128(), rndDiv(i % 3), 1'b0, 1'b0, "R1");
    for (int i = 0; i < 24; i++) runOp(rnd128(), rndDiv(i % 3), 1'b1, 1'b0, "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule